// File: doc/BRIEF.md
# DRAM Page-Mode Controller

This block sits between a simple word-request port and one multiplexed-address asynchronous DRAM with 2048 rows and 2048 columns. The host presents a word address, a direction and write data with a valid/ready handshake. The controller splits the address into a row half and a column half, opens the row with a falling row strobe, and then performs the access with a falling column strobe. All minimum strobe spacings and data latencies are kept as whole clock cycles, set through parameters.

Once a row is open it stays open. A later request to the same row runs a further column cycle without a new row activation (page mode). A request to a different row first closes the row and reopens it only when the row-cycle interval allows. A free-running timer spreads refresh over the retention period. Each refresh is a row-strobe-only cycle on the next row from an internal counter. A pending refresh closes any open page and is served before new host work.

Top module: `dram_page_ctl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high.
- R2: `req_addr[2*HALF_W-1:HALF_W]` is the row and `req_addr[HALF_W-1:0]` is the column. The row is on `dram_addr` when `dram_ras_n` falls and the column when `dram_cas_n` falls. `dram_cas_n` is low only while `dram_ras_n` is low.
- R3: Two falls of `dram_ras_n` are at least `T_RC` cycles apart.
- R4: For a read, `rd_valid` is high for exactly one cycle. That cycle is the later of `T_RAC` cycles after the row strobe fell and `T_CAC` cycles after the column strobe fell. `rd_data` then holds the word stored at the requested address.
- R5: Two falls of `dram_cas_n` are at least `T_PC` cycles apart.
- R6: A request to the row already open, with no refresh in between, runs its column cycle with no new fall of `dram_ras_n`.
- R7: A request to a different row raises `dram_ras_n` and then activates the new row, so at least one fall of `dram_ras_n` lies between the two column cycles.
- R8: A write drives `dram_we_n` low and `dram_dq_oe` high, with the data on `dram_dq_out`, while `dram_cas_n` is low. A read keeps `dram_dq_oe` low. A later read returns the written word.
- R9: A refresh is a row-strobe-only cycle. `dram_ras_n` stays low at least `T_RAC` cycles with no column strobe. Its row address counts up from 0 by one per refresh, modulo 2^`HALF_W`.
- R10: A refresh becomes due every `REF_INTERVAL` cycles. It has priority over new host requests, closes an open page and starts within 40 cycles of becoming due.
- R11: `req_ready` is high only when no row is being opened, no column cycle or refresh is running and no refresh is pending. While it is high, `dram_cas_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HALF_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | HALF_W | Multiplexed address pins |
| dram_dq_out | output | DATA_W | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data from the DRAM |

## Verification
The assertions assume the host holds `req_addr`, `req_we` and `req_wdata` stable while `req_valid` waits for `req_ready`. They also assume `dram_dq_in` carries the addressed word by the edge where `rd_valid` is raised. The bench drives requests only at falling edges and holds them until acceptance. Its behavioural DRAM puts stored data on `dram_dq_in` from the cycle the column strobe falls. Traffic is kept to a few rows and columns, so page hits, page misses, writes that are read back and refreshes landing on an open page all occur often.

// File: rtl/dram_page_ctl.sv
module dram_page_ctl #(
  parameter int HALF_W       = 11,
  parameter int DATA_W       = 16,
  parameter int T_RAC        = 6,
  parameter int T_RC         = 11,
  parameter int T_CAC        = 2,
  parameter int T_PC         = 4,
  parameter int REF_INTERVAL = 390
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [2*HALF_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  dram_ras_n,
  output logic                  dram_cas_n,
  output logic                  dram_we_n,
  output logic [HALF_W-1:0]     dram_addr,
  output logic [DATA_W-1:0]     dram_dq_out,
  output logic                  dram_dq_oe,
  input  logic [DATA_W-1:0]     dram_dq_in
);

  localparam int CNT_W = $clog2(T_RC + T_RAC + T_PC + T_CAC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] RC_LIM  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] RAC_LIM = CNT_W'(T_RAC - 1);
  localparam logic [CNT_W-1:0] CAC_LIM = CNT_W'(T_CAC - 1);
  localparam logic [CNT_W-1:0] PC_LIM  = CNT_W'(T_PC - 1);
  localparam int REF_W = $clog2(REF_INTERVAL);
  localparam logic [REF_W-1:0] REF_LIM = REF_W'(REF_INTERVAL - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_CASW, S_COL, S_OPEN, S_RFA, S_RFH
  } state_t;

  state_t             state;
  logic [CNT_W-1:0]   rc_cnt, cas_cnt;
  logic [REF_W-1:0]   ref_tmr;
  logic               ref_pend;
  logic [HALF_W-1:0]  ref_row, open_row, cur_row, cur_col;
  logic               cur_we;
  logic [DATA_W-1:0]  cur_wdata;

  wire [HALF_W-1:0] req_row = req_addr[2*HALF_W-1:HALF_W];
  wire [HALF_W-1:0] req_col = req_addr[HALF_W-1:0];
  wire rc_ok    = rc_cnt >= RC_LIM;
  wire rac_ok   = rc_cnt >= RAC_LIM;
  wire cac_ok   = cas_cnt >= CAC_LIM;
  wire pc_ok    = cas_cnt >= PC_LIM;
  wire take     = req_valid && req_ready;
  wire col_done = cac_ok && (cur_we || rac_ok);
  wire ref_tick = ref_tmr == REF_LIM;
  wire ref_done = (state == S_RFH) && rac_ok;

  assign req_ready = ((state == S_IDLE) || (state == S_OPEN)) && !ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_tmr  <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      ref_tmr  <= ref_tick ? '0 : ref_tmr + 1'b1;
      ref_pend <= ref_tick || (ref_pend && !ref_done);
      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rc_cnt      <= CNT_MAX;
      cas_cnt     <= CNT_MAX;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_dq_out <= '0;
      dram_addr   <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      open_row    <= '0;
      cur_row     <= '0;
      cur_col     <= '0;
      cur_we      <= 1'b0;
      cur_wdata   <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (rc_cnt != CNT_MAX)  rc_cnt  <= rc_cnt + 1'b1;
      if (cas_cnt != CNT_MAX) cas_cnt <= cas_cnt + 1'b1;
      if (take) begin
        cur_row   <= req_row;
        cur_col   <= req_col;
        cur_we    <= req_we;
        cur_wdata <= req_wdata;
      end
      case (state)
        S_IDLE: begin
          if (ref_pend)  state <= S_RFA;
          else if (take) state <= S_ACT;
        end
        S_ACT: if (rc_ok) begin
          dram_ras_n <= 1'b0;
          dram_addr  <= cur_row;
          open_row   <= cur_row;
          rc_cnt     <= '0;
          state      <= S_CASW;
        end
        S_CASW: if (pc_ok) begin
          dram_cas_n  <= 1'b0;
          dram_addr   <= cur_col;
          dram_we_n   <= !cur_we;
          dram_dq_oe  <= cur_we;
          dram_dq_out <= cur_wdata;
          cas_cnt     <= '0;
          state       <= S_COL;
        end
        S_COL: if (col_done) begin
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_dq_oe <= 1'b0;
          if (!cur_we) begin
            rd_valid <= 1'b1;
            rd_data  <= dram_dq_in;
          end
          state <= S_OPEN;
        end
        S_OPEN: begin
          if (ref_pend) begin
            dram_ras_n <= 1'b1;
            state      <= S_IDLE;
          end else if (take) begin
            if (req_row == open_row) begin
              state <= S_CASW;
            end else begin
              dram_ras_n <= 1'b1;
              state      <= S_ACT;
            end
          end
        end
        S_RFA: if (rc_ok) begin
          dram_ras_n <= 1'b0;
          dram_addr  <= ref_row;
          rc_cnt     <= '0;
          state      <= S_RFH;
        end
        S_RFH: if (rac_ok) begin
          dram_ras_n <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  localparam int CHK_W = 16;
  logic [CHK_W-1:0] ras_gap, cas_gap;
  logic             ras_q, cas_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_gap <= '1;
      cas_gap <= '1;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      ras_q <= dram_ras_n;
      cas_q <= dram_cas_n;
      if (ras_q && !dram_ras_n) ras_gap <= CHK_W'(1);
      else if (ras_gap != '1)   ras_gap <= ras_gap + 1'b1;
      if (cas_q && !dram_cas_n) cas_gap <= CHK_W'(1);
      else if (cas_gap != '1)   cas_gap <= cas_gap + 1'b1;
    end
  end

  assert_trc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ras_gap >= CHK_W'(T_RC));
  assert_tpc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> cas_gap >= CHK_W'(T_PC));
  assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ras_gap >= CHK_W'(T_RAC)) && (cas_gap >= CHK_W'(T_CAC)));
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_wr_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (!dram_cas_n && dram_dq_oe));
  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dram_cas_n);

endmodule

// File: tb/test_dram_page_ctl.sv
module test_dram_page_ctl;
  localparam int HW = 11, DW = 16, TRAC = 6, TRC = 11, TCAC = 2, TPC = 4, REFI = 300;
  localparam int NROW = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [2*HW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, dq_in_m = '0;
  logic req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DW-1:0] rd_data, dram_dq_out;
  logic [HW-1:0] dram_addr;

  always #4 clk = ~clk;

  dram_page_ctl #(.HALF_W(HW), .DATA_W(DW), .T_RAC(TRAC), .T_RC(TRC), .T_CAC(TCAC),
    .T_PC(TPC), .REF_INTERVAL(REFI)) i_dram_page_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_m));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [DW-1:0] mem [int];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] hq [$];
  int rdq_t [$];

  always @(posedge clk) cyc++;

  function automatic logic [DW-1:0] dflt(int a);
    return DW'(a) ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // behavioural DRAM with timing checks, sampled on falling edges
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int ras_fall_t = -1000, cas_fall_t = -1000, ref_fall_t = -1;
  int open_row_m = 0, prev_cas_row = -1, falls_since_cas = 0, ref_exp = 0, ref_cnt = 0;
  bit cas_in_act = 0, ref_since_cas = 0;
  int a, t;
  logic [DW-1:0] d;

  always @(negedge clk) if (rst_n) begin
    if (prev_ras && !dram_ras_n) begin
      chk(cyc - ras_fall_t >= TRC, "R3 row-cycle spacing", cyc - ras_fall_t, TRC);
      ras_fall_t = cyc;
      open_row_m = int'(dram_addr);
      cas_in_act = 0;
      falls_since_cas++;
    end
    if (!prev_ras && dram_ras_n && !cas_in_act) begin
      chk(open_row_m == ref_exp, "R9 refresh row", open_row_m, ref_exp);
      chk(cyc - ras_fall_t >= TRAC, "R9 refresh low time", cyc - ras_fall_t, TRAC);
      if (ref_fall_t >= 0) begin
        chk(ras_fall_t - ref_fall_t <= REFI + 40, "R10 refresh spacing max", ras_fall_t - ref_fall_t, REFI + 40);
        chk(ras_fall_t - ref_fall_t >= REFI - 40, "R10 refresh spacing min", ras_fall_t - ref_fall_t, REFI - 40);
      end
      ref_fall_t = ras_fall_t;
      ref_exp = (ref_exp + 1) % NROW;
      ref_since_cas = 1;
      ref_cnt++;
    end
    if (prev_cas && !dram_cas_n) begin
      chk(!dram_ras_n, "R2 column strobe inside row", int'(dram_ras_n), 0);
      chk(cyc - cas_fall_t >= TPC, "R5 column spacing", cyc - cas_fall_t, TPC);
      if (open_row_m == prev_cas_row && !ref_since_cas)
        chk(falls_since_cas == 0, "R6 page hit without activation", falls_since_cas, 0);
      else if (open_row_m != prev_cas_row && prev_cas_row >= 0)
        chk(falls_since_cas >= 1, "R7 new row activated", falls_since_cas, 1);
      prev_cas_row = open_row_m;
      falls_since_cas = 0;
      ref_since_cas = 0;
      cas_fall_t = cyc;
      cas_in_act = 1;
      a = open_row_m * NROW + int'(dram_addr);
      if (!dram_we_n) begin
        chk(dram_dq_oe, "R8 write drives data", int'(dram_dq_oe), 1);
        mem[a] = dram_dq_out;
      end else begin
        chk(!dram_dq_oe, "R8 read leaves bus", int'(dram_dq_oe), 0);
        dq_in_m = mem.exists(a) ? mem[a] : dflt(a);
        t = (ras_fall_t + TRAC > cyc + TCAC) ? ras_fall_t + TRAC : cyc + TCAC;
        rdq_t.push_back(t);
      end
    end
    if (rd_valid) begin
      if (rdq_t.size() == 0) chk(0, "R4 unexpected read pulse", 1, 0);
      else begin
        t = rdq_t.pop_front();
        chk(cyc == t, "R4 read latency", cyc, t);
      end
      if (hq.size() == 0) chk(0, "R8 read data with no request", 1, 0);
      else begin
        d = hq.pop_front();
        chk(rd_data == d, "R2 R8 read data", int'(rd_data), int'(d));
      end
    end
    if (req_ready) chk(dram_cas_n, "R11 ready while column idle", int'(dram_cas_n), 1);
    prev_ras = dram_ras_n;
    prev_cas = dram_cas_n;
  end

  task automatic host(input bit we, input int row, input int col, input logic [DW-1:0] wd);
    int ad;
    ad = row * NROW + col;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = (2*HW)'(ad); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    if (we) shadow[ad] = wd;
    else hq.push_back(shadow.exists(ad) ? shadow[ad] : dflt(ad));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    summary();
  end

  initial begin
    int refs0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    chk(!dram_dq_oe && !rd_valid, "R1 outputs idle", int'({dram_dq_oe, rd_valid}), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);

    for (int c = 0; c < 4; c++) host(1, 5, c, DW'(16'h1000 + c));
    for (int c = 0; c < 4; c++) host(0, 5, c, '0);
    host(1, 9, 7, 16'hBEEF);
    host(0, 5, 1, '0);
    host(0, 9, 7, '0);
    host(0, 3, 3, '0);
    host(1, NROW - 1, NROW - 1, 16'h7E57);
    host(1, 0, 0, 16'h0F0F);
    host(0, NROW - 1, NROW - 1, '0);
    host(0, 0, 0, '0);

    repeat (40) @(negedge clk);
    refs0 = ref_cnt;
    repeat (3 * REFI) @(negedge clk);
    chk(ref_cnt - refs0 >= 2, "R10 refreshes while idle", ref_cnt - refs0, 2);

    for (int i = 0; i < 400; i++) begin
      host(1'($urandom % 2), int'($urandom % 4), int'($urandom % 8), DW'($urandom));
      if ($urandom % 8 == 0) repeat (int'($urandom % 20)) @(negedge clk);
    end

    while (hq.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(rdq_t.size() == 0, "R4 all reads answered", rdq_t.size(), 0);
    chk(ref_cnt >= 10, "R9 refresh count", ref_cnt, 10);
    summary();
  end
endmodule